// File: doc/BRIEF.md
# Two-Button Up/Down Level Controller

This block holds an unsigned level that two push-button lines adjust: one line raises the level and the other lowers it. Both lines are active low and sit high when idle. Each line is brought into the clock domain through a chain of synchronizer flops. It then passes through a two-bit history register, which turns each press (a high-to-low transition) into a pulse one clock cycle long. The two pulses are used only as synchronous enables and never as clocks.

One clocked process looks at both pulses together and settles every cycle. It covers four cases: raise only, lower only, both, and neither. Only that process writes the level register. When both buttons fire in the same cycle, the level holds. The level saturates at its limits and does not wrap. The pulses are also brought out as outputs so a debugger can watch them.

Top module: `updown_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the level is set to 0 after that edge, and both pulse outputs are 0. All synchronizer and history flops reset to 1, the idle level.
- R2: Suppose a button line goes from high to low and is then sampled low at rising edge k. Its pulse output is 1 during the cycle after edge k+2 and nowhere else in that window.
- R3: A pulse lasts exactly one cycle, even when the line stays low for many cycles. The release (low-to-high) makes no pulse. Another pulse needs the line to go high and then fall again.
- R4: When only the raise pulse is 1 and the level is below its maximum, the level goes up by 1 at the next rising edge.
- R5: When only the lower pulse is 1 and the level is above 0, the level goes down by 1 at the next rising edge.
- R6: When both pulses are 1 in the same cycle, the level is unchanged at the next edge.
- R7: A raise pulse while the level is at its maximum (2^VAL_W - 1, which is 255 by default) leaves the level at its maximum.
- R8: A lower pulse while the level is 0 leaves it at 0.
- R9: When neither pulse is 1, the level does not change. This includes the cycles after reset while both lines stay idle high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_up_n | input | 1 | Raw raise button line, active low, asynchronous |
| btn_dn_n | input | 1 | Raw lower button line, active low, asynchronous |
| level | output | VAL_W | Current level |
| up_pulse | output | 1 | One-cycle pulse on each press of the raise button |
| dn_pulse | output | 1 | One-cycle pulse on each press of the lower button |

## Verification
The level is driven in several ways: single presses of each button on their own, a press of both buttons in the same cycle, and long runs of presses that push it against 0 and against 255. Single presses show that each direction moves the level by exactly one step and that the pulse lands in the expected cycle. The simultaneous press tells the hold rule apart from a rule that favours either button. The runs at the limits tell saturation apart from wrap-around. A long hold followed by a release shows that one press gives one pulse and that the rising edge gives none.

// File: rtl/updown_pkg.sv
// Shared definitions for the two-button level controller.
// Assumes channel 0 is the raise button and channel 1 is the lower button.
package updown_pkg;

    localparam int NUM_BTN = 2;
    localparam int CH_UP   = 0;
    localparam int CH_DN   = 1;

    // Action picked by the arbiter in a given cycle.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2
    } level_act_e;

    // Turn the two pulses into one action; both or neither means hold.
    function automatic level_act_e pick_action(input logic up, input logic dn);
        case ({up, dn})
            2'b10:   return ACT_UP;
            2'b01:   return ACT_DOWN;
            default: return ACT_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/line_sync.sv
// Synchronizer chain for one asynchronous button line.
// Assumes the line idles high, so every stage resets to 1 and reset makes no edge.
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the chain; stage 0 takes the raw sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], raw_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/fall_detect.sv
// Falling-edge detector: two-bit history, newest sample in bit 0.
// Gives a one-cycle pulse when the history reads 2'b10 (older 1, newer 0).
// Assumes the input is already synchronous to clk.
module fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_in,
    output logic fall_pulse
);

    logic [1:0] hist;

    // Move the older sample up to bit 1 and load the new one into bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= 2'b11;
        end else begin
            hist <= {hist[0], sample_in};
        end
    end

    assign fall_pulse = (hist == 2'b10);

endmodule

// File: rtl/level_arbiter.sv
// Level register with one writer. It resolves raise/lower/both/neither
// in a single clocked process and saturates at 0 and at 2^VAL_W-1.
// Assumes the pulses are synchronous enables, one cycle each.
module level_arbiter
    import updown_pkg::*;
#(
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_en,
    input  logic             dn_en,
    output logic [VAL_W-1:0] level
);

    localparam logic [VAL_W-1:0] LVL_MAX = {VAL_W{1'b1}};
    localparam logic [VAL_W-1:0] LVL_MIN = '0;

    level_act_e act;

    // Decode both pulses together into a single action.
    always_comb begin
        act = pick_action(up_en, dn_en);
    end

    // Sole writer of the level register; the limits stop any wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= LVL_MIN;
        end else begin
            case (act)
                ACT_UP:   if (level != LVL_MAX) level <= level + 1'b1;
                ACT_DOWN: if (level != LVL_MIN) level <= level - 1'b1;
                default:  level <= level;
            endcase
        end
    end

endmodule

// File: rtl/updown_ctrl.sv
// Top of the two-button level controller. Each raw line goes through a
// synchronizer and a falling-edge detector; the two pulses feed one arbiter.
// Assumes active-low buttons that idle high; no debouncing is done here.
module updown_ctrl #(
    parameter int VAL_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_up_n,
    input  logic             btn_dn_n,
    output logic [VAL_W-1:0] level,
    output logic             up_pulse,
    output logic             dn_pulse
);

    import updown_pkg::*;

    logic [NUM_BTN-1:0] raw_lines;
    logic [NUM_BTN-1:0] synced;
    logic [NUM_BTN-1:0] pulses;

    assign raw_lines[CH_UP] = btn_up_n;
    assign raw_lines[CH_DN] = btn_dn_n;

    // One synchronizer and one edge detector for each button.
    for (genvar g = 0; g < NUM_BTN; g++) begin : g_chan
        line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_lines[g]),
            .sync_out (synced[g])
        );
        fall_detect u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_in  (synced[g]),
            .fall_pulse (pulses[g])
        );
    end

    level_arbiter #(.VAL_W(VAL_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .up_en (pulses[CH_UP]),
        .dn_en (pulses[CH_DN]),
        .level (level)
    );

    assign up_pulse = pulses[CH_UP];
    assign dn_pulse = pulses[CH_DN];

endmodule

// File: rtl/updown_ctrl_chk.sv
// Property checker for updown_ctrl, attached with bind to every instance.
module updown_ctrl_chk #(
    parameter int VAL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VAL_W-1:0] level,
    input logic             up_pulse,
    input logic             dn_pulse
);

    localparam logic [VAL_W-1:0] LMAX = {VAL_W{1'b1}};

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (level == '0 && !up_pulse && !dn_pulse));

    a_r3_up_single: assert property (@(posedge clk) disable iff (!rst_n)
        up_pulse |=> !up_pulse);

    a_r3_dn_single: assert property (@(posedge clk) disable iff (!rst_n)
        dn_pulse |=> !dn_pulse);

    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && !dn_pulse && level != LMAX) |=> level == $past(level) + 1'b1);

    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_pulse && !up_pulse && level != '0) |=> level == $past(level) - 1'b1);

    a_r6_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && dn_pulse) |=> $stable(level));

    a_r7_sat_max: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && !dn_pulse && level == LMAX) |=> level == LMAX);

    a_r8_sat_min: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_pulse && !up_pulse && level == '0) |=> level == '0);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_pulse && !dn_pulse) |=> $stable(level));

endmodule

bind updown_ctrl updown_ctrl_chk #(.VAL_W(VAL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level),
    .up_pulse (up_pulse),
    .dn_pulse (dn_pulse)
);

// File: tb/sim_updown_ctrl.sv
// Directed bench for updown_ctrl: one task per scenario, each checks itself.
module sim_updown_ctrl;

    localparam int VAL_W = 8;
    localparam int LMAX  = (1 << VAL_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             btn_up_n = 1'b1;
    logic             btn_dn_n = 1'b1;
    logic [VAL_W-1:0] level;
    logic             up_pulse;
    logic             dn_pulse;

    int checks = 0;
    int errors = 0;
    int exp_lvl = 0;
    bit done = 0;

    always #5 clk = ~clk;

    updown_ctrl #(.VAL_W(VAL_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_up_n(btn_up_n), .btn_dn_n(btn_dn_n),
        .level(level), .up_pulse(up_pulse), .dn_pulse(dn_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Press the chosen buttons at a falling edge and check the pulses and the level.
    // Timing: sampled low at edge 1, pulse after edge 3, level updated at edge 4.
    task automatic press(input bit up, input bit dn, input string req, input bit chk);
        @(negedge clk);
        btn_up_n = ~up;
        btn_dn_n = ~dn;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (chk) begin
            check("R2 up pulse timing", int'(up_pulse), int'(up));
            check("R2 dn pulse timing", int'(dn_pulse), int'(dn));
        end
        if (up && !dn && exp_lvl < LMAX) exp_lvl++;
        else if (dn && !up && exp_lvl > 0) exp_lvl--;
        @(negedge clk);
        if (chk) check(req, int'(level), exp_lvl);
        btn_up_n = 1'b1;
        btn_dn_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 level", int'(level), 0);
        check("R1 pulses", int'(up_pulse) + int'(dn_pulse), 0);
        rst_n = 1'b1;
        exp_lvl = 0;
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                seen += int'(up_pulse) + int'(dn_pulse);
            end
            check("R9 no pulse after reset", seen, 0);
            check("R9 level idle", int'(level), 0);
        end
    endtask

    task automatic t_single_steps();
        press(1, 0, "R4 raise step", 1);
        press(1, 0, "R4 raise step", 1);
        press(1, 0, "R4 raise step", 1);
        press(0, 1, "R5 lower step", 1);
    endtask

    task automatic t_both();
        press(1, 1, "R6 both hold", 1);
    endtask

    task automatic t_hold_release();
        int ups = 0;
        @(negedge clk);
        btn_up_n = 1'b0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            ups += int'(up_pulse);
        end
        check("R3 one pulse while held", ups, 1);
        if (exp_lvl < LMAX) exp_lvl++;
        check("R3 level after hold", int'(level), exp_lvl);
        ups = 0;
        btn_up_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ups += int'(up_pulse);
        end
        check("R3 no pulse on release", ups, 0);
        check("R3 level after release", int'(level), exp_lvl);
    endtask

    task automatic t_sat_min();
        while (exp_lvl > 0) press(0, 1, "R5 descend", 0);
        check("R5 reached zero", int'(level), 0);
        press(0, 1, "R8 floor hold", 1);
        press(0, 1, "R8 floor hold", 1);
    endtask

    task automatic t_sat_max();
        while (exp_lvl < LMAX) press(1, 0, "R4 ascend", 0);
        check("R4 reached max", int'(level), LMAX);
        press(1, 0, "R7 ceiling hold", 1);
        press(1, 0, "R7 ceiling hold", 1);
        press(1, 1, "R6 both at max", 1);
        press(0, 1, "R5 step from max", 1);
    endtask

    initial begin
        t_reset();
        t_single_steps();
        t_both();
        t_hold_release();
        t_sat_min();
        t_sat_max();
        t_reset();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule